// File: doc/BRIEF.md
# Registered Chip-Select Address Decoder

This block sits between one bus master and a fixed set of slaves. Each slave has a compile-time base address and a compile-time width for its local address port. The block does two things. It passes each slave its local address combinationally. It also registers one chip-select line per slave, which goes high when the master's strobe is high and the master address falls inside that slave's region.

The local address that a slave sees starts at master address bit 1, not bit 0. A slave with a local port W bits wide receives bits W down to 1. Its region is therefore 2^(W+1) master addresses, aligned to that size. The chip-select compares only the master bits above bit W with the same bits of the slave's base address.

The chip-select is a registered output. It appears one clock after the address and strobe that caused it, and an asynchronous reset clears it.

Top module: `strobe_cs_decoder`

## Requirements
- R1: Slave i's local address is driven on `tgt_addr[i*LOC_AW +: LOC_AW]`. It equals master address bits [W_i:1] placed in the low W_i bits of that slot, with the rest of the slot zero.
- R2: A slave with a one-bit local port gets master address bit 1 in bit 0 of its slot, and every other bit of the slot is 0.
- R3: The local address slots are combinational. They follow a change of `mst_addr` within the same cycle, without a clock edge.
- R4: `tgt_cs[i]` rises on the first rising clock edge at which `mst_stb` is 1 and the address matches slave i. It is not high before that edge.
- R5: Slave i matches when master bits [MST_AW-1:W_i+1] equal the same bits of its base address. Bits W_i down to 0 do not affect the match.
- R6: While `mst_stb` is 0, every chip-select is 0 after the next rising edge, even when the address matches.
- R7: A chip-select that is high returns to 0 at the first rising edge at which its match fails.
- R8: A high level on `rst` clears every chip-select at once, without waiting for a clock edge.
- R9: When the slave regions do not overlap, at most one chip-select is high in any cycle.
- R10: A slave with a zero-width local port matches on bits [MST_AW-1:1], so its region is two addresses wide, and its address slot is constantly zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| mst_addr | input | MST_AW | Master byte address |
| mst_stb | input | 1 | Master strobe qualifying the address |
| tgt_addr | output | N_TGT*LOC_AW | Local address slots, one LOC_AW-bit slot per slave |
| tgt_cs | output | N_TGT | Registered chip-select, one bit per slave |

## Verification
The embedded assertions check these rules on every cycle:
- No chip-select is high without the strobe in the previous cycle.
- A low strobe clears all chip-selects one edge later.
- The chip-selects stay mutually exclusive.
- The address slots do not move while the master address is held.
- Reset leaves every chip-select low.

Only the directed scenarios can show the rest:
- The exact bit slices each slave receives, including the one-bit and zero-width slaves.
- The precise region edges, where the low bits are ignored and the first address outside a region misses.
- The one-cycle lag between address and chip-select.
- That reset clears the chip-selects in mid-cycle, with no edge.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    // Width of one field in the packed per-slave width parameter.
    localparam int unsigned AW_FIELD = 8;

    // Mask that keeps the master bits above a slave's local window.
    function automatic logic [63:0] upper_mask(input int unsigned mst_w, input int unsigned loc_w);
        logic [63:0] m;
        m = '0;
        for (int b = 0; b < 64; b++) begin
            if (b < int'(mst_w) && b > int'(loc_w)) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cs_dec_slice.sv
module cs_dec_slice #(
    parameter int unsigned MST_AW = 16,
    parameter int unsigned LOC_AW = 8,
    parameter int unsigned W      = 4
) (
    input  logic [MST_AW-1:0] addr,
    output logic [LOC_AW-1:0] slot
);

    localparam int unsigned PAD = LOC_AW - W;

    generate
        if (W == 0) begin : g_none
            assign slot = '0;
            logic unused_addr;
            assign unused_addr = ^addr;
        end else if (W < LOC_AW) begin : g_pad
            assign slot = {{PAD{1'b0}}, addr[W:1]};
            logic unused_addr;
            assign unused_addr = ^{addr[MST_AW-1:W+1], addr[0]};
        end else begin : g_full
            assign slot = addr[W:1];
            logic unused_addr;
            assign unused_addr = ^{addr[MST_AW-1:W+1], addr[0]};
        end
    endgenerate

endmodule

// File: rtl/cs_dec_match.sv
module cs_dec_match #(
    parameter int unsigned       MST_AW = 16,
    parameter int unsigned       W      = 4,
    parameter logic [MST_AW-1:0] BASE   = '0
) (
    input  logic [MST_AW-1:0] addr,
    output logic              hit
);

    import cs_dec_pkg::*;

    localparam logic [63:0]       MASK_WIDE = upper_mask(MST_AW, W);
    localparam logic [MST_AW-1:0] MASK      = MASK_WIDE[MST_AW-1:0];

    always_comb begin
        hit = ((addr ^ BASE) & MASK) == '0;
    end

endmodule

// File: rtl/strobe_cs_decoder.sv
module strobe_cs_decoder #(
    parameter int unsigned                MST_AW          = 16,
    parameter int unsigned                N_TGT           = 4,
    parameter int unsigned                LOC_AW          = 8,
    parameter logic [N_TGT*8-1:0]         TGT_AW_PACK     = {8'd0, 8'd1, 8'd8, 8'd4},
    parameter logic [N_TGT*MST_AW-1:0]    TGT_BASE_PACK   = {16'h8000, 16'h1000, 16'h0200, 16'h0000},
    parameter bit                         CHECK_EXCLUSIVE = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [MST_AW-1:0]         mst_addr,
    input  logic                      mst_stb,
    output logic [N_TGT*LOC_AW-1:0]   tgt_addr,
    output logic [N_TGT-1:0]          tgt_cs
);

    import cs_dec_pkg::*;

    typedef struct packed {
        logic [N_TGT-1:0] cs;
    } dec_state_t;

    dec_state_t       st_d, st_q;
    logic [N_TGT-1:0] hit_vec;

    generate
        for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
            localparam int unsigned       W_I    = int'(TGT_AW_PACK[i*AW_FIELD +: AW_FIELD]);
            localparam logic [MST_AW-1:0] BASE_I = TGT_BASE_PACK[i*MST_AW +: MST_AW];

            cs_dec_slice #(.MST_AW(MST_AW), .LOC_AW(LOC_AW), .W(W_I)) i_slice (
                .addr (mst_addr),
                .slot (tgt_addr[i*LOC_AW +: LOC_AW])
            );

            cs_dec_match #(.MST_AW(MST_AW), .W(W_I), .BASE(BASE_I)) i_match (
                .addr (mst_addr),
                .hit  (hit_vec[i])
            );

            // R4: a rising chip-select must have been requested with the strobe
            a_r4_rise_needs_strobe : assert property (@(posedge clk) disable iff (rst)
                $rose(tgt_cs[i]) |-> $past(mst_stb));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        st_d.cs = hit_vec & {N_TGT{mst_stb}};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tgt_cs = st_q.cs;

    // R6: no strobe means no chip-select after the next edge
    a_r6_idle_clears : assert property (@(posedge clk) disable iff (rst)
        !mst_stb |=> (tgt_cs == '0));

    // R9: disjoint regions give at most one active chip-select
    a_r9_exclusive : assert property (@(posedge clk) disable iff (rst)
        CHECK_EXCLUSIVE |-> $onehot0(tgt_cs));

    // R3: the slots only move when the master address moves
    a_r3_slots_follow_addr : assert property (@(posedge clk) disable iff (rst)
        $stable(mst_addr) |-> $stable(tgt_addr));

    // R8: reset holds every chip-select low
    a_r8_reset_clear : assert property (@(posedge clk)
        rst |-> (tgt_cs == '0));

endmodule

// File: tb/test_strobe_cs_decoder.sv
module test_strobe_cs_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mst_addr = '0;
    logic        mst_stb = 1'b0;
    logic [31:0] tgt_addr;
    logic [3:0]  tgt_cs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    strobe_cs_decoder i_strobe_cs_decoder (
        .clk      (clk),
        .rst      (rst),
        .mst_addr (mst_addr),
        .mst_stb  (mst_stb),
        .tgt_addr (tgt_addr),
        .tgt_cs   (tgt_cs)
    );

    // Independent model of the regions from the requirements.
    function automatic logic [3:0] model_cs(input logic [15:0] a, input logic s);
        logic [3:0] r;
        r[0] = (a < 16'h0020);
        r[1] = (a >= 16'h0200) && (a < 16'h0400);
        r[2] = (a >= 16'h1000) && (a < 16'h1004);
        r[3] = (a >= 16'h8000) && (a < 16'h8002);
        return s ? r : 4'b0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic s);
        @(negedge clk);
        mst_addr = a;
        mst_stb  = s;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        #1;
        chk("R8 cs during reset", {28'd0, tgt_cs}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_slices;
        @(negedge clk);
        mst_stb  = 1'b0;
        mst_addr = 16'h03A6;
        #1;
        chk("R1 slot0 bits 4:1", {24'd0, tgt_addr[7:0]}, 32'h03);
        chk("R1 slot1 bits 8:1", {24'd0, tgt_addr[15:8]}, 32'hD3);
        chk("R2 slot2 bit1", {24'd0, tgt_addr[23:16]}, 32'h01);
        chk("R10 slot3 zero", {24'd0, tgt_addr[31:24]}, 32'h00);
        #2;
        mst_addr = 16'h03A4;
        #1;
        chk("R3 slot2 follows same cycle", {24'd0, tgt_addr[23:16]}, 32'h00);
        chk("R3 slot1 follows same cycle", {24'd0, tgt_addr[15:8]}, 32'hD2);
    endtask

    task automatic t_latency;
        step(16'h0000, 1'b0);
        @(negedge clk);
        mst_addr = 16'h0210;
        mst_stb  = 1'b1;
        #1;
        chk("R4 no cs before edge", {28'd0, tgt_cs}, 32'd0);
        @(posedge clk);
        #1;
        chk("R4 cs after edge", {28'd0, tgt_cs}, 32'h2);
    endtask

    task automatic t_edges;
        step(16'h0000, 1'b1); chk("R5 s0 low end",    {28'd0, tgt_cs}, 32'h1);
        step(16'h001F, 1'b1); chk("R5 s0 high end",   {28'd0, tgt_cs}, 32'h1);
        step(16'h0020, 1'b1); chk("R5 s0 past end",   {28'd0, tgt_cs}, 32'h0);
        step(16'h03FF, 1'b1); chk("R5 s1 high end",   {28'd0, tgt_cs}, 32'h2);
        step(16'h1003, 1'b1); chk("R2 s2 high end",   {28'd0, tgt_cs}, 32'h4);
        step(16'h1004, 1'b1); chk("R5 s2 past end",   {28'd0, tgt_cs}, 32'h0);
        step(16'h8001, 1'b1); chk("R10 s3 odd addr",  {28'd0, tgt_cs}, 32'h8);
        step(16'h8002, 1'b1); chk("R10 s3 past end",  {28'd0, tgt_cs}, 32'h0);
    endtask

    task automatic t_strobe_low;
        step(16'h0200, 1'b1);
        chk("R6 setup hit", {28'd0, tgt_cs}, 32'h2);
        step(16'h0200, 1'b0);
        chk("R6 strobe low clears", {28'd0, tgt_cs}, 32'h0);
    endtask

    task automatic t_drop;
        step(16'h1001, 1'b1);
        chk("R7 setup hit", {28'd0, tgt_cs}, 32'h4);
        step(16'h2001, 1'b1);
        chk("R7 miss drops cs", {28'd0, tgt_cs}, 32'h0);
    endtask

    task automatic t_async_reset;
        step(16'h8000, 1'b1);
        chk("R8 setup hit", {28'd0, tgt_cs}, 32'h8);
        #2;
        rst = 1'b1;
        #1;
        chk("R8 async clear", {28'd0, tgt_cs}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_sweep;
        for (int k = 0; k < 300; k++) begin
            logic [15:0] a;
            logic        s;
            a = 16'(k * 16'h0107) ^ 16'(k << 12);
            if (k % 7 == 3) a = 16'h0200 + 16'(k);
            if (k % 11 == 5) a = 16'h1000 + 16'(k % 5);
            s = (k % 5) != 0;
            step(a, s);
            chk("R9 sweep model", {28'd0, tgt_cs}, {28'd0, model_cs(a, s)});
            chk("R9 at most one", ($countones(tgt_cs) <= 1) ? 32'd1 : 32'd0, 32'd1);
        end
    endtask

    initial begin
        t_reset();
        t_slices();
        t_latency();
        t_edges();
        t_strobe_low();
        t_drop();
        t_async_reset();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule